// File: doc/BRIEF.md
# Prioritised Edge Interrupt Controller

The block gathers sixteen edge-triggered interrupt sources and one special external line that cannot be masked. Every clock it samples all seventeen inputs and looks for rising and falling edges against the previous sample. A rising edge on a numbered source marks that source pending in an active-low status register. If the source's programmed 3-bit priority level is strictly above a global threshold, the block also reports the source on a 6-bit code output, together with a one-cycle valid strobe. A rising edge on the special line always reports a fixed code. It ignores every register.

Software reaches a small register window through a byte-addressed bus with byte enables. The window holds the pending register at word 0, the threshold at word 1 and four level words at words 4 to 7. The sources are numbered 0 to 6 for external lines 1 to 7, 7 to 10 for DMA channels 3, 2, 1 and 0, 11 to 12 for the two serial ports and 13 to 15 for the three timers. A falling edge on any input produces a "cleared" report, code 0. When several events land in the same cycle, one winner is reported and the others still update their status.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it: pending (byte offset 0x00) reads 0x0000FFFF; threshold (0x04) and the level words (0x10, 0x14, 0x18, 0x1C) read 0; `irq_valid` is 0.
- R2: A rising edge on `src_in[s]` clears bit s of the pending register one cycle later. The bit stays cleared until software writes offset 0x00. If a write and an edge hit the same bit in the same cycle, the bit ends up cleared.
- R3: The level of source s is bits [(s%4)*8+2 : (s%4)*8] of the level word at offset 0x10 + 4*(s/4).
- R4: A rising edge on source s whose level is strictly greater than the 32-bit threshold (unsigned) gives `irq_valid`=1 and `irq_code`=16+s on the cycle after the edge. A level equal to or below the threshold gives no report. Levels and threshold are taken as they stood before any write in that same cycle.
- R5: A rising edge on `nmi_in` gives `irq_valid`=1 and `irq_code`=32 on the next cycle, whatever the registers hold. It leaves the pending register unchanged.
- R6: A falling edge on any input, when no rising edge wins in that cycle, gives `irq_valid`=1 and `irq_code`=0 on the next cycle.
- R7: Among simultaneous events the winner is chosen in this order: the special line first, then the lowest-numbered forwarded source, then any falling edge. Every rising source still clears its pending bit.
- R8: Writes are byte-granular. Only the byte lanes whose `bus_be` bit is set change, with lane i covering bits [8i+7:8i].
- R9: Offsets 0x08 and 0x0C read 0, and writes to them change nothing readable.
- R10: Raising `rst` in the middle of operation restores every R1 value at the next clock.
- R11: In any cycle after which no event is reported, `irq_valid` is 0 and `irq_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 16 | Numbered interrupt sources, bit s = source s |
| nmi_in | input | 1 | Special unmaskable external line |
| bus_addr | input | 5 | Byte address within the register window |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_code | output | 6 | Reported interrupt code, registered |
| irq_valid | output | 1 | One-cycle strobe qualifying `irq_code` |

## Verification
The hardest situation to reach from the ports is a collision. In such a case one cycle holds several rising edges with mixed levels, a falling edge, perhaps the special line, and a bus write to the very register being compared or cleared. Directed steps place two sources at levels just above and exactly at the threshold, and fire them together with the special line. Other directed steps write the pending or threshold word in the same cycle as an edge. A long random phase then toggles all inputs and mixes in random byte-lane writes. A behavioural model predicts the code, strobe and read data on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LVL_W         = 3;
    localparam int CODE_W        = 6;
    localparam int CODE_BASE     = 16;
    localparam int CODE_SPECIAL  = 32;
    localparam int CODE_CLEAR    = 0;
    localparam int WORD_PEND     = 0;
    localparam int WORD_MASK     = 1;
    localparam int WORD_LVL_BASE = 4;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_SPECIAL,
        WIN_SOURCE,
        WIN_CLEAR
    } win_kind_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } irq_evt_t;

    function automatic logic lvl_passes(input logic [LVL_W-1:0] lvl,
                                        input logic [31:0]      thr);
        return {{(32-LVL_W){1'b0}}, lvl} > thr;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DW/8-1:0]       wr_be,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [NSRC-1:0]       evt_clr,
    output logic [DW-1:0]         pend_o,
    output logic [DW-1:0]         thr_o,
    output logic [NSRC*LVL_W-1:0] lvl_o
);
    localparam int NB  = DW / 8;
    localparam int NLW = NSRC / NB;
    localparam int WIW = AW - 2;
    localparam logic [DW-1:0] PEND_INIT = DW'({NSRC{1'b1}});

    logic [DW-1:0]  pend_q;
    logic [DW-1:0]  thr_q;
    logic [DW-1:0]  lvl_q [NLW];
    logic [WIW-1:0] widx;

    assign widx = addr[AW-1:2];

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [NB-1:0] be);
        logic [DW-1:0] r;
        r = old_v;
        for (int b = 0; b < NB; b++)
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

    logic hit_pend, hit_thr;
    assign hit_pend = wr_en && (int'(widx) == WORD_PEND);
    assign hit_thr  = wr_en && (int'(widx) == WORD_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= PEND_INIT;
            thr_q  <= '0;
        end else begin
            pend_q <= (hit_pend ? lane_merge(pend_q, wdata, wr_be) : pend_q)
                      & ~DW'(evt_clr);
            if (hit_thr) thr_q <= lane_merge(thr_q, wdata, wr_be);
        end
    end

    for (genvar w = 0; w < NLW; w++) begin : g_lvl_word
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[w] <= '0;
            else if (wr_en && (int'(widx) == WORD_LVL_BASE + w))
                lvl_q[w] <= lane_merge(lvl_q[w], wdata, wr_be);
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl_field
        assign lvl_o[s*LVL_W +: LVL_W] = lvl_q[s/NB][(s%NB)*8 +: LVL_W];
    end

    always_comb begin
        rdata = '0;
        if (int'(widx) == WORD_PEND)      rdata = pend_q;
        else if (int'(widx) == WORD_MASK) rdata = thr_q;
        else begin
            for (int w = 0; w < NLW; w++)
                if (int'(widx) == WORD_LVL_BASE + w) rdata = lvl_q[w];
        end
    end

    assign pend_o = pend_q;
    assign thr_o  = thr_q;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       src_rise,
    input  logic [NSRC-1:0]       src_fall,
    input  logic                  sp_rise,
    input  logic                  sp_fall,
    input  logic [NSRC*LVL_W-1:0] lvl,
    input  logic [31:0]           thr,
    output irq_evt_t              evt_o
);
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] fwd;
    win_kind_t       kind;
    logic [IW-1:0]   win_idx;
    logic            found;
    irq_evt_t        evt_d, evt_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_fwd
        assign fwd[s] = src_rise[s] && lvl_passes(lvl[s*LVL_W +: LVL_W], thr);
    end

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (!found && fwd[s]) begin
                found   = 1'b1;
                win_idx = IW'(s);
            end
        end
        if (sp_rise)                      kind = WIN_SPECIAL;
        else if (found)                   kind = WIN_SOURCE;
        else if ((|src_fall) || sp_fall)  kind = WIN_CLEAR;
        else                              kind = WIN_NONE;
    end

    always_comb begin
        evt_d = '0;
        unique case (kind)
            WIN_SPECIAL: evt_d = '{valid: 1'b1, code: CODE_W'(CODE_SPECIAL)};
            WIN_SOURCE:  evt_d = '{valid: 1'b1,
                                   code: CODE_W'(CODE_BASE) + CODE_W'(win_idx)};
            WIN_CLEAR:   evt_d = '{valid: 1'b1, code: CODE_W'(CODE_CLEAR)};
            default:     evt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_d;
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    src_in,
    input  logic               nmi_in,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW/8-1:0]    bus_be,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [CODE_W-1:0]  irq_code,
    output logic               irq_valid
);
    localparam int NIN = NSRC + 1;

    logic [NIN-1:0]         rise_w, fall_w;
    logic [DW-1:0]          pend_w, thr_w;
    logic [NSRC*LVL_W-1:0]  lvl_w;
    irq_evt_t               evt_w;

    irqc_edge #(.W(NIN)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  ({nmi_in, src_in}),
        .rise (rise_w),
        .fall (fall_w)
    );

    irqc_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .wr_be   (bus_be),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .evt_clr (rise_w[NSRC-1:0]),
        .pend_o  (pend_w),
        .thr_o   (thr_w),
        .lvl_o   (lvl_w)
    );

    irqc_arb #(.NSRC(NSRC)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .src_rise (rise_w[NSRC-1:0]),
        .src_fall (fall_w[NSRC-1:0]),
        .sp_rise  (rise_w[NSRC]),
        .sp_fall  (fall_w[NSRC]),
        .lvl      (lvl_w),
        .thr      (thr_w[31:0]),
        .evt_o    (evt_w)
    );

    assign irq_valid = evt_w.valid;
    assign irq_code  = evt_w.code;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NSRC = 16,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_in,
    input logic            nmi_in,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [5:0]      irq_code,
    input logic            irq_valid,
    input logic [DW-1:0]   pend
);
    logic [NSRC-1:0] src_s;
    logic            nmi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_s <= '0;
            nmi_s <= 1'b0;
        end else begin
            src_s <= src_in;
            nmi_s <= nmi_in;
        end
    end

    // R1 / R10: reset restores pending word and silences output
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pend == DW'({NSRC{1'b1}})) && !irq_valid);

    // R11: code is zero whenever no strobe
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> irq_code == 6'd0);

    // R4: a strobed code is one of the legal values
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_code == 6'd0 || irq_code == 6'd32 ||
                       (irq_code >= 6'd16 && irq_code < 6'(16 + NSRC))));

    // R5: special line rising edge always reports code 32
    a_r5_special: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !nmi_s) |=> irq_valid && irq_code == 6'd32);

    // R6: a falling edge with no rising edge yields a clear report
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (((src_s & ~src_in) != '0 || (nmi_s && !nmi_in)) &&
         (src_in & ~src_s) == '0 && !(nmi_in && !nmi_s))
        |=> irq_valid && irq_code == 6'd0);

    // R2: pending bits only return high through a write to word 0
    a_r2_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (!bus_we || bus_addr[AW-1:2] != '0) |=> (pend & ~$past(pend)) == '0);

    // R2: a rising source is cleared in the pending word next cycle
    a_r2_pend_clear: assert property (@(posedge clk) disable iff (rst)
        ((src_in & ~src_s) != '0) |=> (pend[NSRC-1:0] & $past(src_in & ~src_s)) == '0);
endmodule

bind irq_prio_ctrl irqc_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .nmi_in    (nmi_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .irq_code  (irq_code),
    .irq_valid (irq_valid),
    .pend      (pend_w)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src_in;
    logic        nmi_in;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [5:0]  irq_code;
    logic        irq_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .src_in(src_in), .nmi_in(nmi_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_code(irq_code), .irq_valid(irq_valid)
    );

    // behavioural reference state
    logic [31:0] m_pend, m_thr;
    logic [31:0] m_lvl [4];
    logic [15:0] m_prev;
    logic        m_prevn;
    logic        e_valid;
    logic [5:0]  e_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic int lvl_of(int s);
        return int'(m_lvl[s/4][(s%4)*8 +: 3]);
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a[4:2])
            3'd0: return m_pend;
            3'd1: return m_thr;
            3'd4: return m_lvl[0];
            3'd5: return m_lvl[1];
            3'd6: return m_lvl[2];
            3'd7: return m_lvl[3];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic model_reset();
        m_pend = 32'h0000FFFF; m_thr = 0;
        for (int w = 0; w < 4; w++) m_lvl[w] = 0;
        m_prev = 0; m_prevn = 0; e_valid = 0; e_code = 0;
    endtask

    task automatic step(string tag);
        logic [15:0] rs, fl;
        logic        nr, nf;
        bit          got;
        if (rst) model_reset();
        else begin
            rs = src_in & ~m_prev; fl = ~src_in & m_prev;
            nr = nmi_in && !m_prevn; nf = !nmi_in && m_prevn;
            got = 0; e_valid = 0; e_code = 0;
            if (nr) begin e_valid = 1; e_code = 6'd32; got = 1; end
            for (int s = 0; s < 16; s++)
                if (!got && rs[s] && (32'(lvl_of(s)) > m_thr)) begin
                    e_valid = 1; e_code = 6'(16 + s); got = 1;
                end
            if (!got && (fl != 0 || nf)) begin e_valid = 1; e_code = 0; end
            if (bus_we) begin
                case (bus_addr[4:2])
                    3'd0: m_pend = merge(m_pend, bus_wdata, bus_be);
                    3'd1: m_thr  = merge(m_thr, bus_wdata, bus_be);
                    3'd4, 3'd5, 3'd6, 3'd7:
                        m_lvl[bus_addr[3:2]] = merge(m_lvl[bus_addr[3:2]], bus_wdata, bus_be);
                    default: ;
                endcase
            end
            m_pend = m_pend & ~{16'h0, rs};
            m_prev = src_in; m_prevn = nmi_in;
        end
        @(posedge clk);
        #1;
        n_cmp++;
        if (irq_valid !== e_valid || irq_code !== e_code || bus_rdata !== m_read(bus_addr)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b code=%0d rdata=%08h expected valid=%0b code=%0d rdata=%08h",
                     tag, irq_valid, irq_code, bus_rdata, e_valid, e_code, m_read(bus_addr));
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be, string tag);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1;
        step(tag);
        bus_we = 0;
    endtask

    task automatic rd(logic [4:0] a, string tag);
        bus_addr = a;
        step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1; src_in = 0; nmi_in = 0; bus_addr = 0; bus_we = 0; bus_be = 0; bus_wdata = 0;
        model_reset();
        repeat (3) step("R1");
        rst = 0;
        // R1 reset values through the bus
        rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h10, "R1"); rd(5'h1C, "R1");
        // R8 byte-lane writes
        wr(5'h10, 32'h05040302, 4'b0101, "R8");
        rd(5'h10, "R8");
        wr(5'h14, 32'h07060504, 4'b1111, "R8");
        wr(5'h1C, 32'hFF030201, 4'b0011, "R8");
        rd(5'h1C, "R8");
        // R9 unmapped offsets
        wr(5'h08, 32'hDEADBEEF, 4'b1111, "R9");
        rd(5'h08, "R9"); rd(5'h0C, "R9");
        // R4 forwarding with threshold 0: source 0 level 2 forwards
        rd(5'h00, "R4");
        src_in[0] = 1; step("R4");
        step("R11");
        // R2 / R4 source 1 level 0 is not above 0: pending only
        src_in[1] = 1; step("R2");
        step("R2");
        // R3 level field of source 5 (lane 1 of 0x14), threshold 4
        wr(5'h04, 32'h4, 4'b0001, "R4");
        src_in[5] = 1; step("R3");
        src_in[4] = 1; step("R4");
        // R6 falling edge reports clear
        src_in[5] = 0; step("R6");
        step("R11");
        // R5 special line with high threshold
        wr(5'h04, 32'h0100_0000, 4'b1000, "R5");
        nmi_in = 1; step("R5");
        nmi_in = 0; step("R6");
        src_in[7] = 1; step("R4");
        wr(5'h04, 32'h4, 4'b1111, "R4");
        // R7 simultaneous special + source; then two sources + a fall
        src_in[7] = 0; step("R6");
        nmi_in = 1; src_in[6] = 1; step("R7");
        src_in[6] = 0; src_in[7] = 1; src_in[4] = 0; step("R7");
        nmi_in = 0; src_in[6] = 1; src_in[7] = 0; src_in[14] = 1; step("R7");
        // R2 software restores pending, same-cycle edge wins
        bus_addr = 5'h00; src_in[15] = 1;
        wr(5'h00, 32'h0000FFFF, 4'b0011, "R2");
        rd(5'h00, "R2");
        // R4 same-cycle threshold write uses old threshold
        src_in = 0; step("R6");
        bus_addr = 5'h04; bus_wdata = 32'h7; bus_be = 4'hF; bus_we = 1;
        src_in[0] = 1; step("R4");
        bus_we = 0;
        // R10 mid-run reset
        rst = 1; step("R10");
        rst = 0; src_in = 0; rd(5'h10, "R10"); rd(5'h00, "R10");
        // random mix, all requirements
        for (int i = 0; i < 3000; i++) begin
            src_in = src_in ^ 16'($urandom_range(0, 65535) & $urandom_range(0, 65535));
            if ($urandom_range(0, 7) == 0) nmi_in = ~nmi_in;
            bus_addr = 5'($urandom_range(0, 31)) & 5'h1C;
            bus_we = ($urandom_range(0, 3) == 0);
            bus_be = 4'($urandom_range(0, 15));
            bus_wdata = $urandom & 32'h0707_0707;
            if ($urandom_range(0, 3) == 0) bus_wdata = $urandom;
            if (bus_addr == 5'h04) bus_wdata = bus_wdata & 32'h7;
            rst = ($urandom_range(0, 499) == 0);
            step("R7");
        end
        rst = 0; bus_we = 0;
        step("R11");
        finish_run();
    end
endmodule